// File: doc/BRIEF.md
# USB Endpoint Handshake Control Registers

This block holds the per-endpoint control and status state for a small USB device core. Every endpoint number has an OUT and an IN direction. The two directions are folded into one endpoint address, `(number << 1) | dir`. Software reaches the state through a simple register port, which has a write strobe, a word address and a combinational read-data output. Through this port it sets the arm, stall and data-toggle vectors, clears pending events, enables interrupts, and keeps a buffer pointer and a length word for each endpoint address.

The protocol engine presents an endpoint address on `ep_addr_i`. For that address it gets back the handshake to send and the current data-toggle value. When a transaction completes, the engine pulses `done_i` with the same address. That pulse latches a pending event for the address and flips its data toggle.

While a pending event is outstanding, the endpoint answers NAK. This lets software drain or refill the packet buffer before it re-arms the endpoint. By software convention, received OUT payload ends two positions before the final buffer position, because the two CRC16 bytes are also counted there.

Top module: `usb_ep_ctrl_regs`

## Requirements
- R1: An endpoint address is `(number << 1) | dir`, where dir 1 is IN and dir 0 is OUT. Bit k of every vector register belongs to address k. With 3 endpoint numbers, addresses 6 and 7 answer NAK, read toggle 0, and `done_i` on them changes nothing.
- R2: After reset, the arm, stall, toggle, pending and enable registers all read 0, every address answers NAK, and `irq_o` is 0.
- R3: `resp_o` encodes the handshake as NAK=2'b00, ACK=2'b01 and STALL=2'b10. A set stall bit gives STALL. Otherwise an armed address with no pending event gives ACK. Every other case gives NAK.
- R4: Word offsets 0, 1 and 2 hold the arm, stall and toggle vectors, and a write replaces the whole vector. Bits above bit 5, and unmapped offsets 5 to 7, read as 0.
- R5: A `done_i` pulse sets the pending bit of `ep_addr_i`, visible one clock later.
- R6: The pending vector at offset 3 is write-1-to-clear. A 0 bit in the written word leaves its pending bit unchanged.
- R7: A clear of a pending bit is refused when `done_i` targets the same address in the same cycle. In that case the bit stays 1.
- R8: Each `done_i` inverts the toggle bit of its address, and `dtog_o` shows the toggle bit of `ep_addr_i`. A software write to offset 2 in the same cycle takes priority over the inversion.
- R9: `irq_o` is 1 exactly when some pending bit has its enable bit set. The enable vector sits at offset 4.
- R10: Offset 8+2k holds the buffer pointer of address k, and offset 9+2k holds its length. Both are 10 bits wide, and upper written bits are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register word offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| ep_addr_i | input | 3 | Endpoint address from the protocol engine |
| done_i | input | 1 | Transaction completion pulse for `ep_addr_i` |
| resp_o | output | 2 | Handshake for `ep_addr_i` |
| dtog_o | output | 1 | Data-toggle bit for `ep_addr_i` |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a completion pulse and a software write landing in the same cycle. This happens in two forms: a clear of the pending bit for the address being completed, and a write of the toggle vector while that address flips. The bench drives the register port and the engine side from a single cycle task, so both arrive on one edge by construction. It repeats the collision with the clear aimed at the same address and at a neighbouring address, so a refused clear can be told apart from a lost set. A reference model with integer vectors predicts every output on every cycle, including the handshake of the address under test while the register port reads something else.

// File: rtl/usb_ep_pkg.sv
package usb_ep_pkg;
  typedef enum logic [1:0] {
    RESP_NAK   = 2'b00,
    RESP_ACK   = 2'b01,
    RESP_STALL = 2'b10
  } resp_e;

  localparam int unsigned OFS_ARM   = 0;
  localparam int unsigned OFS_STALL = 1;
  localparam int unsigned OFS_TOG   = 2;
  localparam int unsigned OFS_PEND  = 3;
  localparam int unsigned OFS_IEN   = 4;
  localparam int unsigned OFS_BUF   = 8;
endpackage

// File: rtl/ep_bitvec_reg.sv
module ep_bitvec_reg #(
  parameter int unsigned N  = 6,
  parameter int unsigned IW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [N-1:0]  wdata_i,
  input  logic          flip_i,
  input  logic [IW-1:0] flip_idx_i,
  output logic [N-1:0]  q_o
);
  logic flip_ok;
  logic [N-1:0] flip_vec;

  assign flip_ok = flip_i && (flip_idx_i < IW'(N));

  always_comb begin
    flip_vec = '0;
    if (flip_ok) flip_vec[flip_idx_i] = 1'b1;
  end

  // software write beats hardware inversion
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (wr_i) q_o <= wdata_i;
    else           q_o <= q_o ^ flip_vec;
  end

  a_r8_flip_on_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flip_ok && !wr_i |=> q_o[$past(flip_idx_i)] != $past(q_o[flip_idx_i]));

  // R4 and R8: a write lands as written, even with a flip in the same cycle
  a_r4_write_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> q_o == $past(wdata_i));
endmodule

// File: rtl/ep_event_bank.sv
module ep_event_bank #(
  parameter int unsigned N  = 6,
  parameter int unsigned IW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          set_i,
  input  logic [IW-1:0] set_idx_i,
  input  logic          clr_we_i,
  input  logic [N-1:0]  clr_mask_i,
  input  logic          en_we_i,
  input  logic [N-1:0]  en_wdata_i,
  output logic [N-1:0]  pend_o,
  output logic [N-1:0]  en_o,
  output logic          irq_o
);
  logic set_ok;
  logic [N-1:0] set_vec, clr_vec;

  assign set_ok  = set_i && (set_idx_i < IW'(N));
  assign clr_vec = clr_we_i ? clr_mask_i : '0;

  always_comb begin
    set_vec = '0;
    if (set_ok) set_vec[set_idx_i] = 1'b1;
  end

  // set after clear: a completing address cannot be cleared this cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_o <= '0;
      en_o   <= '0;
    end else begin
      pend_o <= (pend_o & ~clr_vec) | set_vec;
      if (en_we_i) en_o <= en_wdata_i;
    end
  end

  assign irq_o = |(pend_o & en_o);

  a_r5_set_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_ok |=> pend_o[$past(set_idx_i)]);

  a_r7_clear_refused: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_ok && clr_we_i && clr_mask_i[set_idx_i] |=> pend_o[$past(set_idx_i)]);

  a_r6_zero_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_we_i && !set_i |=> (pend_o & ~$past(clr_mask_i)) == ($past(pend_o) & ~$past(clr_mask_i)));
endmodule

// File: rtl/ep_resp_decode.sv
module ep_resp_decode
  import usb_ep_pkg::*;
#(
  parameter int unsigned N  = 6,
  parameter int unsigned IW = 3
) (
  input  logic [N-1:0]  stall_i,
  input  logic [N-1:0]  arm_i,
  input  logic [N-1:0]  pend_i,
  input  logic [N-1:0]  tog_i,
  input  logic [IW-1:0] idx_i,
  output resp_e         resp_o,
  output logic          tog_o
);
  logic valid;
  assign valid = idx_i < IW'(N);

  always_comb begin
    resp_o = RESP_NAK;
    tog_o  = 1'b0;
    if (valid) begin
      tog_o = tog_i[idx_i];
      if (stall_i[idx_i])                     resp_o = RESP_STALL;
      else if (arm_i[idx_i] && !pend_i[idx_i]) resp_o = RESP_ACK;
    end
  end
endmodule

// File: rtl/ep_ptr_len_store.sv
module ep_ptr_len_store #(
  parameter int unsigned ENTRIES = 12,
  parameter int unsigned AW      = 10,
  parameter int unsigned SW      = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [SW-1:0] sel_i,
  input  logic [AW-1:0] wdata_i,
  output logic [AW-1:0] rdata_o
);
  logic [AW-1:0] word_q [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           word_q[g] <= '0;
      else if (we_i && sel_i == SW'(g))      word_q[g] <= wdata_i;
    end
  end

  assign rdata_o = (sel_i < SW'(ENTRIES)) ? word_q[sel_i] : '0;
endmodule

// File: rtl/usb_ep_ctrl_regs.sv
module usb_ep_ctrl_regs
  import usb_ep_pkg::*;
#(
  parameter int unsigned NUM_EP = 3,
  parameter int unsigned DW     = 32,
  parameter int unsigned BUF_AW = 10
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                reg_we_i,
  input  logic [4:0]          reg_addr_i,
  input  logic [DW-1:0]       reg_wdata_i,
  output logic [DW-1:0]       reg_rdata_o,
  input  logic [2:0]          ep_addr_i,
  input  logic                done_i,
  output logic [1:0]          resp_o,
  output logic                dtog_o,
  output logic                irq_o
);
  localparam int unsigned N       = 2 * NUM_EP;
  localparam int unsigned IW      = 3;
  localparam int unsigned RAW     = 5;
  localparam int unsigned ENTRIES = 2 * N;
  localparam int unsigned SW      = $clog2(ENTRIES);

  logic [N-1:0] arm_q, stall_q, tog_q, pend_q, en_q;
  logic wr_arm, wr_stall, wr_tog, wr_pend, wr_ien, wr_buf, buf_hit;
  logic [RAW-1:0] buf_off;
  logic [BUF_AW-1:0] buf_rd;
  resp_e resp;

  assign buf_hit  = (reg_addr_i >= RAW'(OFS_BUF)) && (reg_addr_i < RAW'(OFS_BUF + ENTRIES));
  assign buf_off  = reg_addr_i - RAW'(OFS_BUF);
  assign wr_arm   = reg_we_i && reg_addr_i == RAW'(OFS_ARM);
  assign wr_stall = reg_we_i && reg_addr_i == RAW'(OFS_STALL);
  assign wr_tog   = reg_we_i && reg_addr_i == RAW'(OFS_TOG);
  assign wr_pend  = reg_we_i && reg_addr_i == RAW'(OFS_PEND);
  assign wr_ien   = reg_we_i && reg_addr_i == RAW'(OFS_IEN);
  assign wr_buf   = reg_we_i && buf_hit;

  ep_bitvec_reg #(.N(N), .IW(IW)) u_arm (
    .clk_i, .rst_ni, .wr_i(wr_arm), .wdata_i(reg_wdata_i[N-1:0]),
    .flip_i(1'b0), .flip_idx_i('0), .q_o(arm_q));

  ep_bitvec_reg #(.N(N), .IW(IW)) u_stall (
    .clk_i, .rst_ni, .wr_i(wr_stall), .wdata_i(reg_wdata_i[N-1:0]),
    .flip_i(1'b0), .flip_idx_i('0), .q_o(stall_q));

  ep_bitvec_reg #(.N(N), .IW(IW)) u_tog (
    .clk_i, .rst_ni, .wr_i(wr_tog), .wdata_i(reg_wdata_i[N-1:0]),
    .flip_i(done_i), .flip_idx_i(ep_addr_i), .q_o(tog_q));

  ep_event_bank #(.N(N), .IW(IW)) u_evt (
    .clk_i, .rst_ni, .set_i(done_i), .set_idx_i(ep_addr_i),
    .clr_we_i(wr_pend), .clr_mask_i(reg_wdata_i[N-1:0]),
    .en_we_i(wr_ien), .en_wdata_i(reg_wdata_i[N-1:0]),
    .pend_o(pend_q), .en_o(en_q), .irq_o(irq_o));

  ep_resp_decode #(.N(N), .IW(IW)) u_dec (
    .stall_i(stall_q), .arm_i(arm_q), .pend_i(pend_q), .tog_i(tog_q),
    .idx_i(ep_addr_i), .resp_o(resp), .tog_o(dtog_o));

  ep_ptr_len_store #(.ENTRIES(ENTRIES), .AW(BUF_AW), .SW(SW)) u_buf (
    .clk_i, .rst_ni, .we_i(wr_buf), .sel_i(buf_off[SW-1:0]),
    .wdata_i(reg_wdata_i[BUF_AW-1:0]), .rdata_o(buf_rd));

  assign resp_o = resp;

  always_comb begin
    reg_rdata_o = '0;
    if (buf_hit) reg_rdata_o = DW'(buf_rd);
    else begin
      case (reg_addr_i)
        RAW'(OFS_ARM):   reg_rdata_o = DW'(arm_q);
        RAW'(OFS_STALL): reg_rdata_o = DW'(stall_q);
        RAW'(OFS_TOG):   reg_rdata_o = DW'(tog_q);
        RAW'(OFS_PEND):  reg_rdata_o = DW'(pend_q);
        RAW'(OFS_IEN):   reg_rdata_o = DW'(en_q);
        default:         reg_rdata_o = '0;
      endcase
    end
  end

  a_r3_stall_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ep_addr_i < IW'(N)) && stall_q[ep_addr_i] |-> resp_o == RESP_STALL);

  a_r3_ack_when_armed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ep_addr_i < IW'(N)) && !stall_q[ep_addr_i] && arm_q[ep_addr_i] && !pend_q[ep_addr_i]
    |-> resp_o == RESP_ACK);

  a_r1_unmapped_nak: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ep_addr_i >= IW'(N) |-> resp_o == RESP_NAK && !dtog_o);
endmodule

// File: tb/usb_ep_ctrl_regs_test.sv
`timescale 1ns/1ps
module usb_ep_ctrl_regs_test;
  logic clk = 0, rst_n = 0;
  logic we = 0, done = 0;
  logic [4:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic [2:0] ep = 0;
  logic [1:0] resp;
  logic dtog, irq;

  int errors = 0, checks = 0;
  bit finished = 0;
  int m_arm = 0, m_stall = 0, m_tog = 0, m_pend = 0, m_en = 0;
  int m_buf [12];

  always #2.5 clk = ~clk;

  usb_ep_ctrl_regs uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .ep_addr_i(ep), .done_i(done),
    .resp_o(resp), .dtog_o(dtog), .irq_o(irq));

  function automatic int exp_rd(int a);
    case (a)
      0: return m_arm;
      1: return m_stall;
      2: return m_tog;
      3: return m_pend;
      4: return m_en;
      default: return (a >= 8 && a < 20) ? m_buf[a-8] : 0;
    endcase
  endfunction

  function automatic int exp_resp(int e);
    if (e > 5) return 0;
    if ((m_stall >> e) & 1) return 2;
    if (((m_arm >> e) & 1) && !((m_pend >> e) & 1)) return 1;
    return 0;
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: got 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  // one cycle: drive, compare against model, clock, advance model
  task automatic cyc(bit w, int a, logic [31:0] wd, bit dn, int e, string tag);
    int p;
    we = w; addr = 5'(a); wdata = wd; done = dn; ep = 3'(e);
    #1;
    chk(tag, "rdata", int'(rdata), exp_rd(a));
    chk(tag, "resp", int'(resp), exp_resp(e));
    chk(tag, "dtog", int'(dtog), (e < 6) ? ((m_tog >> e) & 1) : 0);
    chk(tag, "irq", int'(irq), ((m_pend & m_en) != 0) ? 1 : 0);
    @(posedge clk);
    p = m_pend;
    if (w && a == 3) p &= ~int'(wd & 32'h3f);
    if (dn && e < 6) p |= 1 << e;
    if (w && a == 2) m_tog = int'(wd & 32'h3f);
    else if (dn && e < 6) m_tog ^= 1 << e;
    m_pend = p;
    if (w) begin
      if (a == 0) m_arm = int'(wd & 32'h3f);
      if (a == 1) m_stall = int'(wd & 32'h3f);
      if (a == 4) m_en = int'(wd & 32'h3f);
      if (a >= 8 && a < 20) m_buf[a-8] = int'(wd & 32'h3ff);
    end
    @(negedge clk);
    we = 0; done = 0;
  endtask

  task automatic set_resp(int e, int r, string tag);
    int s, a;
    s = (r == 2) ? (m_stall | (1 << e)) : (m_stall & ~(1 << e));
    a = (r == 1) ? (m_arm | (1 << e)) : (m_arm & ~(1 << e));
    cyc(1, 1, 32'(s), 0, e, tag);
    cyc(1, 0, 32'(a), 0, e, tag);
    cyc(0, 0, 0, 0, e, tag);
    chk(tag, "resp code", int'(resp), r);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 12; i++) m_buf[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R2 reset values
    for (int a = 0; a < 8; a++) cyc(0, a, 0, 0, a, "R2");
    // R4 whole-vector writes, upper bits dropped
    cyc(1, 0, 32'hffff_ffff, 0, 0, "R4");
    cyc(0, 0, 0, 0, 3, "R4");
    cyc(1, 2, 32'h0000_0015, 0, 0, "R4");
    cyc(0, 2, 0, 0, 2, "R4");
    cyc(1, 2, 0, 0, 0, "R4");
    cyc(1, 0, 0, 0, 0, "R4");
    cyc(1, 5, 32'hffff_ffff, 0, 0, "R4");
    cyc(0, 5, 0, 0, 0, "R4");
    // R3 priority
    cyc(1, 0, 32'h2, 0, 1, "R3");
    cyc(1, 1, 32'h2, 0, 1, "R3");
    cyc(0, 0, 0, 0, 1, "R3");
    chk("R3", "stall over arm", int'(resp), 2);
    set_resp(1, 1, "R3");
    set_resp(1, 2, "R3");
    set_resp(1, 0, "R3");
    set_resp(1, 1, "R3");
    // R5 completion sets pending, R3 then gives NAK
    cyc(0, 3, 0, 1, 1, "R5");
    cyc(0, 3, 0, 0, 1, "R5");
    chk("R5", "pending bit", int'(rdata), 2);
    chk("R3", "nak while pending", int'(resp), 0);
    // R6 write-1-to-clear
    cyc(1, 3, 0, 0, 1, "R6");
    cyc(1, 3, 32'h3d, 0, 1, "R6");
    cyc(0, 3, 0, 0, 1, "R6");
    chk("R6", "zeros kept", int'(rdata), 2);
    cyc(1, 3, 32'h2, 0, 1, "R6");
    cyc(0, 3, 0, 0, 1, "R6");
    chk("R6", "cleared", int'(rdata), 0);
    // R7 clear refused on same-cycle completion
    cyc(0, 3, 0, 1, 4, "R7");
    cyc(1, 3, 32'h10, 1, 4, "R7");
    cyc(0, 3, 0, 0, 4, "R7");
    chk("R7", "kept pending", int'(rdata), 16);
    cyc(1, 3, 32'h10, 1, 2, "R7");
    cyc(0, 3, 0, 0, 2, "R7");
    chk("R7", "other addr clears", int'(rdata), 4);
    cyc(1, 3, 32'h3f, 0, 0, "R7");
    // R8 toggle flips, write wins
    cyc(0, 2, 0, 0, 0, "R8");
    cyc(0, 2, 0, 1, 0, "R8");
    cyc(0, 2, 0, 0, 0, "R8");
    chk("R8", "dtog after done", int'(dtog), 1);
    cyc(0, 2, 0, 1, 0, "R8");
    cyc(1, 2, 32'h1, 1, 0, "R8");
    cyc(0, 2, 0, 0, 0, "R8");
    chk("R8", "write beats flip", int'(rdata), 1);
    cyc(1, 2, 0, 1, 3, "R8");
    cyc(0, 2, 0, 0, 3, "R8");
    cyc(1, 3, 32'h3f, 0, 0, "R8");
    // R1 endpoint 2 IN is address 5; unmapped addresses do nothing
    cyc(0, 3, 0, 1, 5, "R1");
    cyc(0, 3, 0, 0, 5, "R1");
    chk("R1", "ep2 IN bit", int'(rdata), 32);
    cyc(0, 3, 0, 1, 6, "R1");
    cyc(0, 3, 0, 1, 7, "R1");
    cyc(0, 2, 0, 0, 7, "R1");
    // R9 interrupt masking
    cyc(0, 4, 0, 0, 5, "R9");
    chk("R9", "masked", int'(irq), 0);
    cyc(1, 4, 32'h20, 0, 5, "R9");
    cyc(0, 4, 0, 0, 5, "R9");
    chk("R9", "enabled", int'(irq), 1);
    cyc(1, 4, 32'h1f, 0, 5, "R9");
    cyc(0, 4, 0, 1, 0, "R9");
    cyc(0, 4, 0, 0, 0, "R9");
    chk("R9", "addr0 enabled", int'(irq), 1);
    cyc(1, 3, 32'h3f, 0, 0, "R9");
    cyc(0, 3, 0, 0, 0, "R9");
    // R10 pointer and length storage
    for (int k = 0; k < 12; k++) cyc(1, 8 + k, 32'((k * 77 + 5) | 32'hf000), 0, 1, "R10");
    for (int k = 0; k < 12; k++) cyc(0, 8 + k, 0, 0, 1, "R10");
    cyc(1, 9, 32'h000f_ffff, 0, 0, "R10");
    cyc(0, 9, 0, 0, 0, "R10");
    chk("R10", "len width", int'(rdata), 32'h3ff);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule